// File: doc/BRIEF.md
# FIFO Threshold Offset Configuration Unit

This unit keeps the almost-empty and almost-full threshold offsets for a pair of FIFOs. A flag generator elsewhere compares fill levels against these values. The unit does not generate flags and holds no FIFO data.

The setup method is chosen on each clock edge at which master reset is high. A 3-bit select input picks one of five preset offsets, serial loading or parallel loading. With a preset, all four thresholds take the chosen value at once and the unit reports that setup is complete. In parallel mode, qualified writes on a 36-bit data port fill the four offsets one per write, in a fixed order. In serial mode, a bit stream is shifted in one bit per clock while serial-enable is high.

A parity option is latched at master reset. When it is set, parallel loads skip data bit 8. Partial reset only pauses loading: it leaves the offsets, the chosen method and the done state as they are. Once the first FIFO write has been seen, the parallel load window is closed.

Top module: `flagcfg_unit`

## Requirements
- R1: While `rst_ni` is low, all four offsets read 64 and `done_o` is 1. The unit then behaves as if a preset-64 master reset had been applied with parity off.
- R2: A clock edge with `mrst_i` high and `sel_i` equal to 0, 1, 2, 3 or 4 sets all four offsets to 8, 16, 64, 256 or 1024 respectively. `done_o` reads 1 from that edge on.
- R3: A clock edge with `mrst_i` high and `sel_i` equal to 5 selects serial mode; 6 or 7 selects parallel mode. In both cases all offsets become 0 and `done_o` becomes 0.
- R4: In parallel mode, each accepted write loads one offset. A write is accepted on an edge with `wr_en_i` high and with `mrst_i`, `prst_i` and `fifo_wr_i` all low. The loads go in the order FIFO0 almost-empty, FIFO0 almost-full, FIFO1 almost-empty, FIFO1 almost-full. `done_o` rises on the edge of the fourth accepted write.
- R5: With parity off (`parity_i` low at master reset), a parallel load takes `data_i[12:0]`. With parity on, it takes `{data_i[13:9], data_i[7:0]}`, so bit 8 has no effect.
- R6: In parallel mode, an edge with `fifo_wr_i` high (and `mrst_i`, `prst_i` low) closes the load window until the next master reset. A write on that same edge is rejected.
- R7: In serial mode, each edge with `ser_en_i` high (and `mrst_i`, `prst_i` low) shifts `ser_d_i` in, MSB first. The first 13 bits form FIFO0 almost-empty, then FIFO0 almost-full, FIFO1 almost-empty and FIFO1 almost-full. `done_o` rises on the edge of the 52nd bit.
- R8: While `prst_i` is high and `mrst_i` is low, writes, shifts and `fifo_wr_i` are ignored. The offsets and `done_o` are held.
- R9: Once `done_o` is 1, offsets change only through master reset. Changes on `sel_i` or `parity_i` while `mrst_i` is low have no effect.
- R10: Stimulus for the method that was not selected is ignored. `ser_en_i` has no effect in parallel or preset mode, and `wr_en_i` has no effect in serial or preset mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Write-side clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mrst_i | input | 1 | Synchronous master reset; samples `sel_i` and `parity_i` |
| prst_i | input | 1 | Partial reset; pauses loading and keeps the configuration |
| sel_i | input | 3 | Method select: 0..4 preset, 5 serial, 6..7 parallel |
| parity_i | input | 1 | Parity option: skip data bit 8 in parallel loads |
| wr_en_i | input | 1 | Qualified offset write strobe |
| fifo_wr_i | input | 1 | First FIFO write marker; closes the parallel window |
| data_i | input | 36 | Parallel offset data |
| ser_en_i | input | 1 | Serial shift enable |
| ser_d_i | input | 1 | Serial offset data |
| ae_o | output | 26 | Almost-empty offsets; FIFO j in bits [13j+12:13j] |
| af_o | output | 26 | Almost-full offsets; FIFO j in bits [13j+12:13j] |
| done_o | output | 1 | Offset setup complete |

## Verification
The hardest states to reach from the ports are a closed parallel window with only some offsets loaded, and a serial stream partway through with partial reset pulses inside it. Both need long, ordered runs of stimulus after a specific master reset. The directed part of the bench builds each one: it loads one word and then marks a FIFO write, and it interleaves partial-reset cycles inside a 52-bit serial stream. Seeded random rounds then vary the method, the parity option and the mix of write, shift, partial-reset and FIFO-write strobes. A cycle-level model checks every cycle of those rounds.

// File: rtl/flagcfg_pkg.sv
`timescale 1ns/1ps
package flagcfg_pkg;
  typedef enum logic [1:0] {
    MODE_PRESET   = 2'd0,
    MODE_SERIAL   = 2'd1,
    MODE_PARALLEL = 2'd2
  } mode_e;

  localparam logic [2:0] SEL_SERIAL = 3'd5;
  localparam logic [2:0] SEL_RST_PRESET = 3'd2;

  // preset index 0..4 -> shift amount for 8,16,64,256,1024
  function automatic int unsigned preset_shift(logic [2:0] idx);
    if (idx < 3'd2) return 32'd3 + 32'(idx);
    return 32'd2 + 32'd2 * 32'(idx);
  endfunction
endpackage

// File: rtl/flagcfg_mode_latch.sv
`timescale 1ns/1ps
module flagcfg_mode_latch
  import flagcfg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       mrst_i,
  input  logic [2:0] sel_i,
  input  logic       parity_i,
  output mode_e      mode_o,
  output logic       parity_o
);
  mode_e mode_q;
  logic  parity_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= MODE_PRESET;
      parity_q <= 1'b0;
    end else if (mrst_i) begin
      parity_q <= parity_i;
      if (sel_i < SEL_SERIAL)       mode_q <= MODE_PRESET;
      else if (sel_i == SEL_SERIAL) mode_q <= MODE_SERIAL;
      else                          mode_q <= MODE_PARALLEL;
    end
  end

  assign mode_o   = mode_q;
  assign parity_o = parity_q;

  // R9
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mrst_i |=> $stable(mode_q) && $stable(parity_q));
endmodule

// File: rtl/flagcfg_par_loader.sv
`timescale 1ns/1ps
module flagcfg_par_loader #(
  parameter int unsigned OFS_W   = 13,
  parameter int unsigned DATA_W  = 36,
  parameter int unsigned N_FLD   = 4,
  parameter int unsigned PAR_BIT = 8,
  localparam int unsigned IDX_W  = (N_FLD > 1) ? $clog2(N_FLD) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mrst_i,
  input  logic              act_i,
  input  logic              en_i,
  input  logic              wr_en_i,
  input  logic              fifo_wr_i,
  input  logic              done_i,
  input  logic              parity_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              load_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [OFS_W-1:0]  val_o,
  output logic              last_o
);
  logic [IDX_W-1:0] idx_q;
  logic             closed_q;
  logic             unused_data;

  assign unused_data = ^data_i[DATA_W-1:OFS_W+1];

  assign load_o = act_i & en_i & wr_en_i & ~fifo_wr_i & ~closed_q & ~done_i;
  assign last_o = load_o & (idx_q == IDX_W'(N_FLD - 1));
  assign idx_o  = idx_q;

  always_comb begin
    if (parity_i) val_o = {data_i[OFS_W:PAR_BIT+1], data_i[PAR_BIT-1:0]};
    else          val_o = data_i[OFS_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q    <= '0;
      closed_q <= 1'b0;
    end else if (mrst_i) begin
      idx_q    <= '0;
      closed_q <= 1'b0;
    end else begin
      if (act_i && en_i && fifo_wr_i) closed_q <= 1'b1;
      if (load_o) idx_q <= idx_q + 1'b1;
    end
  end

  // R6
  window_closed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    closed_q && !mrst_i |=> closed_q);
  // R4
  idx_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o && !mrst_i |=> idx_q == $past(idx_q) + 1'b1);
endmodule

// File: rtl/flagcfg_ser_shifter.sv
`timescale 1ns/1ps
module flagcfg_ser_shifter #(
  parameter int unsigned TOTAL  = 52,
  localparam int unsigned CNT_W = $clog2(TOTAL + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mrst_i,
  input  logic act_i,
  input  logic en_i,
  input  logic ser_en_i,
  input  logic done_i,
  output logic shift_o,
  output logic last_o
);
  logic [CNT_W-1:0] cnt_q;

  assign shift_o = act_i & en_i & ser_en_i & ~done_i;
  assign last_o  = shift_o & (cnt_q == CNT_W'(TOTAL - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (mrst_i)  cnt_q <= '0;
    else if (shift_o) cnt_q <= cnt_q + 1'b1;
  end

  // R7
  ser_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_o |-> cnt_q < CNT_W'(TOTAL));
  // R7
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(TOTAL));
endmodule

// File: rtl/flagcfg_unit.sv
`timescale 1ns/1ps
module flagcfg_unit
  import flagcfg_pkg::*;
#(
  parameter int unsigned OFS_W   = 13,
  parameter int unsigned N_FIFO  = 2,
  parameter int unsigned DATA_W  = 36,
  parameter int unsigned PAR_BIT = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    mrst_i,
  input  logic                    prst_i,
  input  logic [2:0]              sel_i,
  input  logic                    parity_i,
  input  logic                    wr_en_i,
  input  logic                    fifo_wr_i,
  input  logic [DATA_W-1:0]       data_i,
  input  logic                    ser_en_i,
  input  logic                    ser_d_i,
  output logic [N_FIFO*OFS_W-1:0] ae_o,
  output logic [N_FIFO*OFS_W-1:0] af_o,
  output logic                    done_o
);
  localparam int unsigned N_FLD = 2 * N_FIFO;
  localparam int unsigned TOTAL = N_FLD * OFS_W;
  localparam int unsigned IDX_W = (N_FLD > 1) ? $clog2(N_FLD) : 1;

  mode_e            mode;
  logic             parity;
  logic             act;
  logic             par_load, par_last, ser_shift, ser_last;
  logic [IDX_W-1:0] par_idx;
  logic [OFS_W-1:0] par_val;
  logic             done_q;
  logic [OFS_W-1:0] fld_q [N_FLD];
  logic             chain_in [N_FLD];
  logic [TOTAL-1:0] all_q;

  assign act = ~mrst_i & ~prst_i;

  flagcfg_mode_latch u_mode (
    .clk_i, .rst_ni, .mrst_i, .sel_i, .parity_i,
    .mode_o(mode), .parity_o(parity)
  );

  flagcfg_par_loader #(
    .OFS_W(OFS_W), .DATA_W(DATA_W), .N_FLD(N_FLD), .PAR_BIT(PAR_BIT)
  ) u_par (
    .clk_i, .rst_ni, .mrst_i, .act_i(act), .en_i(mode == MODE_PARALLEL),
    .wr_en_i, .fifo_wr_i, .done_i(done_q), .parity_i(parity), .data_i,
    .load_o(par_load), .idx_o(par_idx), .val_o(par_val), .last_o(par_last)
  );

  flagcfg_ser_shifter #(.TOTAL(TOTAL)) u_ser (
    .clk_i, .rst_ni, .mrst_i, .act_i(act), .en_i(mode == MODE_SERIAL),
    .ser_en_i, .done_i(done_q), .shift_o(ser_shift), .last_o(ser_last)
  );

  for (genvar k = 0; k < N_FLD; k++) begin : g_fld
    if (k == N_FLD - 1) begin : g_tail
      assign chain_in[k] = ser_d_i;
    end else begin : g_link
      assign chain_in[k] = fld_q[k+1][OFS_W-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        fld_q[k] <= OFS_W'(1) << preset_shift(SEL_RST_PRESET);
      else if (mrst_i)
        fld_q[k] <= (sel_i < SEL_SERIAL) ? OFS_W'(1) << preset_shift(sel_i) : '0;
      else if (ser_shift)
        fld_q[k] <= {fld_q[k][OFS_W-2:0], chain_in[k]};
      else if (par_load && par_idx == IDX_W'(k))
        fld_q[k] <= par_val;
    end

    assign all_q[(N_FLD-1-k)*OFS_W +: OFS_W] = fld_q[k];
  end

  for (genvar j = 0; j < N_FIFO; j++) begin : g_out
    assign ae_o[j*OFS_W +: OFS_W] = fld_q[2*j];
    assign af_o[j*OFS_W +: OFS_W] = fld_q[2*j+1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  done_q <= 1'b1;
    else if (mrst_i)              done_q <= (sel_i < SEL_SERIAL);
    else if (par_last | ser_last) done_q <= 1'b1;
  end

  assign done_o = done_q;

  // R9
  frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q && !mrst_i |=> $stable(all_q));
  // R8
  prst_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prst_i && !mrst_i |=> $stable(all_q) && $stable(done_q));
  // R3
  prog_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mrst_i && sel_i >= SEL_SERIAL |=> !done_q && all_q == '0);
  // R4
  done_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mrst_i && !done_q |=> done_q == $past(par_last | ser_last));
endmodule

// File: tb/flagcfg_unit_bench.sv
`timescale 1ns/1ps
module flagcfg_unit_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mrst = 0, prst = 0, parity = 0, wr_en = 0, fifo_wr = 0;
  logic        ser_en = 0, ser_d = 0;
  logic [2:0]  sel = 0;
  logic [35:0] data = '0;
  logic [25:0] ae, af;
  logic        done;

  int n_chk = 0, n_fail = 0;
  logic [12:0] m_fld [4];
  logic        m_done;
  int          m_mode, m_idx;
  logic        m_par, m_closed;

  always #(CLK_P/2) clk = ~clk;

  flagcfg_unit u_flagcfg_unit (
    .clk_i(clk), .rst_ni(rst_n), .mrst_i(mrst), .prst_i(prst), .sel_i(sel),
    .parity_i(parity), .wr_en_i(wr_en), .fifo_wr_i(fifo_wr), .data_i(data),
    .ser_en_i(ser_en), .ser_d_i(ser_d), .ae_o(ae), .af_o(af), .done_o(done)
  );

  function automatic logic [12:0] preset_of(int s);
    case (s)
      0: return 13'd8;
      1: return 13'd16;
      2: return 13'd64;
      3: return 13'd256;
      default: return 13'd1024;
    endcase
  endfunction

  function automatic logic [12:0] par_val(logic [35:0] d, logic p);
    return p ? {d[13:9], d[7:0]} : d[12:0];
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk(tag, 64'(ae), 64'({m_fld[2], m_fld[0]}));
    chk(tag, 64'(af), 64'({m_fld[3], m_fld[1]}));
    chk(tag, 64'(done), 64'(m_done));
  endtask

  task automatic model_reset();
    for (int k = 0; k < 4; k++) m_fld[k] = 13'd64;
    m_done = 1; m_mode = 0; m_par = 0; m_idx = 0; m_closed = 0;
  endtask

  // update model from current inputs, then advance one edge
  task automatic cyc();
    logic [51:0] v;
    if (mrst) begin
      m_par = parity; m_idx = 0; m_closed = 0;
      m_mode = (sel < 5) ? 0 : (sel == 5) ? 1 : 2;
      for (int k = 0; k < 4; k++) m_fld[k] = (sel < 5) ? preset_of(int'(sel)) : 13'd0;
      m_done = (sel < 5);
    end else if (!prst) begin
      if (m_mode == 2) begin
        if (fifo_wr) m_closed = 1;
        else if (wr_en && !m_closed && !m_done) begin
          m_fld[m_idx] = par_val(data, m_par);
          m_idx++;
          if (m_idx == 4) m_done = 1;
        end
      end
      if (m_mode == 1 && ser_en && !m_done) begin
        v = {m_fld[0], m_fld[1], m_fld[2], m_fld[3]};
        v = {v[50:0], ser_d};
        {m_fld[0], m_fld[1], m_fld[2], m_fld[3]} = v;
        m_idx++;
        if (m_idx == 52) m_done = 1;
      end
    end
    @(posedge clk);
    #1;
  endtask

  task automatic do_mrst(int s, logic p);
    sel = 3'(s); parity = p; mrst = 1;
    cyc();
    mrst = 0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_P * 100000);
    n_chk++; n_fail++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    int seed;
    logic [51:0] stream;
    seed = int'($urandom(32'd4242));
    model_reset();
    #(CLK_P*2 + 3);
    check_all("R1");
    rst_n = 1;
    cyc(); check_all("R1");

    for (int s = 0; s < 5; s++) begin
      do_mrst(s, 0); check_all("R2");
      chk("R2", 64'(ae[12:0]), 64'(preset_of(s)));
      cyc(); check_all("R2");
    end

    // parallel, parity off
    do_mrst(6, 0); check_all("R3");
    for (int i = 0; i < 4; i++) begin
      data = {$urandom, $urandom}; wr_en = 1; cyc(); check_all("R4");
    end
    data = '1; cyc(); check_all("R9");
    wr_en = 0; sel = 1; parity = 1; cyc(); check_all("R9");

    // parallel, parity on: bit 8 ignored
    do_mrst(7, 1); check_all("R3");
    for (int i = 0; i < 4; i++) begin
      data = 36'h100 | 36'(i * 36'h1234); wr_en = 1; cyc(); check_all("R5");
    end
    wr_en = 0;
    chk("R5", 64'(ae[12:0]), 64'(par_val(36'h100, 1)));

    // window close by FIFO write
    do_mrst(6, 0);
    data = 36'h0aaa; wr_en = 1; cyc(); check_all("R6");
    wr_en = 0; fifo_wr = 1; cyc(); fifo_wr = 0;
    data = 36'h0555; wr_en = 1; cyc(); check_all("R6");
    wr_en = 0;
    do_mrst(6, 0);
    data = 36'h0777; wr_en = 1; fifo_wr = 1; cyc(); check_all("R6");
    wr_en = 0; fifo_wr = 0;

    // partial reset in parallel mode
    do_mrst(6, 0);
    prst = 1; wr_en = 1; data = 36'h0123; cyc(); check_all("R8");
    fifo_wr = 1; cyc(); fifo_wr = 0; prst = 0; cyc(); check_all("R8");
    ser_en = 1; ser_d = 1; wr_en = 0; cyc(); check_all("R10");
    ser_en = 0;

    // serial
    do_mrst(5, 0); check_all("R3");
    stream = {$urandom, $urandom};
    wr_en = 1; data = 36'h0fff; cyc(); check_all("R10");
    wr_en = 0;
    for (int i = 51; i >= 0; i--) begin
      ser_d = stream[i]; ser_en = 1;
      if (i == 30) begin
        prst = 1; cyc(); check_all("R8"); prst = 0;
      end
      cyc(); check_all("R7");
    end
    chk("R7", 64'({ae[12:0], af[12:0], ae[25:13], af[25:13]}), 64'(stream));
    ser_d = ~ser_d; cyc(); check_all("R9");
    ser_en = 0;

    // random rounds
    for (int r = 0; r < 12; r++) begin
      do_mrst(int'($urandom_range(0, 7)), 1'($urandom));
      check_all("R10");
      for (int c = 0; c < 120; c++) begin
        wr_en   = ($urandom_range(0, 3) == 0);
        fifo_wr = ($urandom_range(0, 40) == 0);
        ser_en  = ($urandom_range(0, 1) == 0);
        prst    = ($urandom_range(0, 15) == 0);
        ser_d   = 1'($urandom);
        data    = {$urandom, $urandom};
        sel     = 3'($urandom);
        parity  = 1'($urandom);
        cyc(); check_all("R10");
      end
      wr_en = 0; fifo_wr = 0; ser_en = 0; prst = 0;
    end

    summary();
  end
endmodule